// File: doc/BRIEF.md
# Four-Phase Non-Overlapping Switch Sequencer

This block produces the gate-enable timing for a charge pump that has two flying capacitors and twelve power switches, six per capacitor. It runs a repeating cycle of four phases. The first and third phases charge both capacitors from the input supply. In the second phase capacitor A drives the positive rail and capacitor B drives the negative rail. In the fourth phase the two capacitors swap rails. The split into four phases comes from a charge/pump toggle bit and a second toggle that alternates the two pumping arrangements.

Each phase is `PHASE_CYCLES` clocks long. Every phase opens with a dead window in which all twelve enables are low. The window length comes from a dead-time input, which is sampled once at the start of each phase and clamped to a legal range. Because of this window, the switches of one phase are always off before any switch of the next phase turns on. A two-bit phase index and a valid flag report where the sequence stands. The valid flag is low in the dead window and whenever the block is idle.

The reset input is active low. It takes effect at once and is released on the clock. All outputs are registered.

Top module: `pump_phase_seq`

## Requirements
- R1: While `rst_n` is low, `sw_a`, `sw_b`, `phase_idx` and `phase_valid` are all zero.
- R2: When `en` is sampled low at a rising edge, all outputs are zero from the second edge after it. When `en` is next sampled high at edge E, the sequence restarts at phase index 0, and `phase_idx` shows 0 from edge E+1.
- R3: While enabled, the phase index advances 0, 1, 2, 3, 0 and so on. Each value is held for exactly `PHASE_CYCLES` clocks at the ports.
- R4: In phase indices 0 and 2, when valid, the enables are `sw_a = 6'b000011` and `sw_b = 6'b000011`. Bit i of each bus drives switch i+1 of that capacitor, so switches 1 and 2 connect it to the input supply.
- R5: In phase index 1, when valid, the enables are `sw_a = 6'b001100` (A pumps to the positive rail through switches 3 and 4) and `sw_b = 6'b110000` (B pumps to the negative rail through switches 5 and 6).
- R6: In phase index 3, when valid, the enables are `sw_a = 6'b110000` and `sw_b = 6'b001100`.
- R7: The first D port cycles of every phase have all twelve enables low and `phase_valid` low. The remaining `PHASE_CYCLES`-D cycles of the phase have `phase_valid` high. D is the effective dead time.
- R8: The effective dead time D is the `dead_cyc` value, with two exceptions. A value of 0 is treated as 1. A value of `PHASE_CYCLES` or more is treated as `PHASE_CYCLES`-1.
- R9: `dead_cyc` is sampled only at the edge where a phase begins. A change during a phase does not alter that phase's dead window.
- R10: For each capacitor, at most one switch pair (1-2, 3-4 or 5-6) is on at any time, and both switches of a pair are always on or off together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en | input | 1 | Run enable; low stops the sequence and turns every switch off |
| dead_cyc | input | DT_W | Requested dead-time length in clocks |
| sw_a | output | 6 | Gate enables of capacitor A, bit i = switch i+1 |
| sw_b | output | 6 | Gate enables of capacitor B, bit i = switch i+1 |
| phase_idx | output | 2 | Current phase index, 0 to 3 |
| phase_valid | output | 1 | High when the current phase's switches are on |

## Verification
The hardest case to reach from the ports is a `dead_cyc` change in the middle of a phase. Such a change must leave the running window alone, but it must be picked up at the next phase boundary. The stimulus reaches this case by following the phase position in the bench model. It raises the setting above the current count partway through a phase, which exposes any design that compares against the live input. Random segments then mix out-of-range dead times, short enable drops and enable toggles that land at arbitrary points in a phase. These segments exercise the restart and clamp behaviour across the wrap from phase 3 back to phase 0.

// File: rtl/pump_seq_pkg.sv
package pump_seq_pkg;

  // Bit positions inside a six-switch bus (switch number minus one)
  localparam int unsigned SW_CHG_LO = 0;
  localparam int unsigned SW_POS_LO = 2;
  localparam int unsigned SW_NEG_LO = 4;

  typedef logic [5:0] sw6_t;

  typedef struct packed {
    sw6_t b;
    sw6_t a;
  } sw_pair_t;

  function automatic sw6_t pair_mask(input int unsigned lo);
    sw6_t m;
    m = '0;
    m[lo]     = 1'b1;
    m[lo + 1] = 1'b1;
    return m;
  endfunction

  // Phase index bit 0: charge (0) / pump (1); bit 1 selects which
  // capacitor feeds the positive rail while pumping.
  function automatic sw_pair_t phase_switches(input logic [1:0] ph, input logic on);
    sw_pair_t r;
    r = '0;
    if (on) begin
      if (!ph[0]) begin
        r.a = pair_mask(SW_CHG_LO);
        r.b = pair_mask(SW_CHG_LO);
      end else if (!ph[1]) begin
        r.a = pair_mask(SW_POS_LO);
        r.b = pair_mask(SW_NEG_LO);
      end else begin
        r.a = pair_mask(SW_NEG_LO);
        r.b = pair_mask(SW_POS_LO);
      end
    end
    return r;
  endfunction

endpackage

// File: rtl/pump_rst_sync.sv
module pump_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain_q <= '0;
    end else begin
      chain_q <= {chain_q[STAGES-2:0], 1'b1};
    end
  end

  assign rst_sync_n = chain_q[STAGES-1];

endmodule

// File: rtl/pump_phase_timer.sv
module pump_phase_timer #(
  parameter int unsigned PHASE_CYCLES = 8,
  parameter int unsigned DT_W         = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            en,
  input  logic [DT_W-1:0] dead_cyc,
  output logic [1:0]      phase,
  output logic            active
);

  localparam int unsigned CNT_W = (PHASE_CYCLES > 2) ? $clog2(PHASE_CYCLES) : 1;
  localparam int unsigned CMP_W = ((DT_W > CNT_W) ? DT_W : CNT_W) + 1;
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(PHASE_CYCLES - 1);
  localparam logic [CMP_W-1:0] DT_MAX   = CMP_W'(PHASE_CYCLES - 1);

  logic             run_q, run_d;
  logic [1:0]       ph_q, ph_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [CNT_W-1:0] dt_q;
  logic [CNT_W-1:0] dt_eff;
  logic [CMP_W-1:0] dead_ext;
  logic             dt_load;

  // Clamp the requested window into 1 .. PHASE_CYCLES-1
  always_comb begin
    dead_ext = CMP_W'(dead_cyc);
    if (dead_ext == '0) begin
      dt_eff = CNT_W'(1);
    end else if (dead_ext > DT_MAX) begin
      dt_eff = CNT_W'(DT_MAX);
    end else begin
      dt_eff = CNT_W'(dead_ext);
    end
  end

  always_comb begin
    run_d   = run_q;
    ph_d    = ph_q;
    cnt_d   = cnt_q;
    dt_load = 1'b0;
    if (!en) begin
      run_d = 1'b0;
      ph_d  = 2'd0;
      cnt_d = '0;
    end else if (!run_q) begin
      run_d   = 1'b1;
      ph_d    = 2'd0;
      cnt_d   = '0;
      dt_load = 1'b1;
    end else if (cnt_q == CNT_LAST) begin
      ph_d    = 2'(ph_q + 2'd1);
      cnt_d   = '0;
      dt_load = 1'b1;
    end else begin
      cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q <= 1'b0;
      ph_q  <= 2'd0;
      cnt_q <= '0;
      dt_q  <= CNT_W'(1);
    end else begin
      run_q <= run_d;
      ph_q  <= ph_d;
      cnt_q <= cnt_d;
      if (dt_load) begin
        dt_q <= dt_eff;
      end
    end
  end

  assign phase  = ph_q;
  assign active = run_q && (cnt_q >= dt_q);

  // R3: phase only moves forward by one step while running
  p_phase_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (run_q && $past(run_q) && (ph_q != $past(ph_q))) |-> (ph_q == 2'($past(ph_q) + 2'd1)));

  // R2: a fresh start always lands on phase 0, count 0
  p_restart_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (run_q && !$past(run_q)) |-> (ph_q == 2'd0 && cnt_q == '0));

  // R8: the first cycle of any phase is never active
  p_dead_min_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q == '0) |-> !active);

endmodule

// File: rtl/pump_switch_map.sv
module pump_switch_map
  import pump_seq_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] phase,
  input  logic       active,
  output logic [5:0] sw_a,
  output logic [5:0] sw_b,
  output logic [1:0] phase_o,
  output logic       valid_o
);

  sw_pair_t sw_d, sw_q;
  logic [1:0] ph_q;
  logic       v_q;

  always_comb begin
    sw_d = phase_switches(phase, active);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sw_q <= '0;
      ph_q <= 2'd0;
      v_q  <= 1'b0;
    end else begin
      sw_q <= sw_d;
      ph_q <= phase;
      v_q  <= active;
    end
  end

  assign sw_a    = sw_q.a;
  assign sw_b    = sw_q.b;
  assign phase_o = ph_q;
  assign valid_o = v_q;

  // R10: one pair at most per capacitor, pair halves move together
  p_one_pair_a_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({sw_a[5] | sw_a[4], sw_a[3] | sw_a[2], sw_a[1] | sw_a[0]}) &&
    (sw_a[0] == sw_a[1]) && (sw_a[2] == sw_a[3]) && (sw_a[4] == sw_a[5]));

  p_one_pair_b_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({sw_b[5] | sw_b[4], sw_b[3] | sw_b[2], sw_b[1] | sw_b[0]}) &&
    (sw_b[0] == sw_b[1]) && (sw_b[2] == sw_b[3]) && (sw_b[4] == sw_b[5]));

  // R7: nothing conducts outside a valid window, and valid means two pairs on
  p_valid_gate_r7: assert property (@(posedge clk) disable iff (!rst_n)
    valid_o ? ($countones({sw_b, sw_a}) == 4) : ({sw_b, sw_a} == 12'd0));

endmodule

// File: rtl/pump_phase_seq.sv
module pump_phase_seq #(
  parameter int unsigned PHASE_CYCLES = 8,
  parameter int unsigned DT_W         = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            en,
  input  logic [DT_W-1:0] dead_cyc,
  output logic [5:0]      sw_a,
  output logic [5:0]      sw_b,
  output logic [1:0]      phase_idx,
  output logic            phase_valid
);

  logic       rst_s_n;
  logic [1:0] ph_int;
  logic       act_int;

  pump_rst_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_s_n)
  );

  pump_phase_timer #(
    .PHASE_CYCLES (PHASE_CYCLES),
    .DT_W         (DT_W)
  ) u_timer (
    .clk      (clk),
    .rst_n    (rst_s_n),
    .en       (en),
    .dead_cyc (dead_cyc),
    .phase    (ph_int),
    .active   (act_int)
  );

  pump_switch_map u_map (
    .clk     (clk),
    .rst_n   (rst_s_n),
    .phase   (ph_int),
    .active  (act_int),
    .sw_a    (sw_a),
    .sw_b    (sw_b),
    .phase_o (phase_idx),
    .valid_o (phase_valid)
  );

  // R7: any change of phase index at the ports falls inside a dead window
  p_gap_r7: assert property (@(posedge clk) disable iff (!rst_s_n)
    (phase_idx != $past(phase_idx)) |-> !phase_valid);

  // R2: two edges after en is seen low, everything is off
  p_off_r2: assert property (@(posedge clk) disable iff (!rst_s_n)
    !$past(en, 2) |-> ({sw_b, sw_a} == 12'd0 && phase_idx == 2'd0 && !phase_valid));

endmodule

// File: tb/pump_phase_seq_test.sv
module pump_phase_seq_test;

  localparam int CLK_PERIOD = 10;
  localparam int P          = 8;
  localparam int DW         = 4;

  logic          clk;
  logic          rst_n;
  logic          en;
  logic [DW-1:0] dead;
  logic [5:0]    sw_a, sw_b;
  logic [1:0]    phase_idx;
  logic          phase_valid;

  int  n_cmp;
  int  n_bad;
  bit  done;
  bit  in_reset;
  bit  r9_mark;

  pump_phase_seq #(.PHASE_CYCLES(P), .DT_W(DW)) uut (
    .clk         (clk),
    .rst_n       (rst_n),
    .en          (en),
    .dead_cyc    (dead),
    .sw_a        (sw_a),
    .sw_b        (sw_b),
    .phase_idx   (phase_idx),
    .phase_valid (phase_valid)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic int eff_dead(input int d);
    if (d == 0) return 1;        // R8 low clamp
    if (d >= P) return P - 1;    // R8 high clamp
    return d;
  endfunction

  function automatic logic [11:0] exp_switches(input int ph, input bit on);
    logic [5:0] a, b;
    a = 6'b0; b = 6'b0;
    if (on) begin
      case (ph)
        0, 2: begin a = 6'b000011; b = 6'b000011; end   // R4
        1:    begin a = 6'b001100; b = 6'b110000; end   // R5
        default: begin a = 6'b110000; b = 6'b001100; end // R6
      endcase
    end
    return {b, a};
  endfunction

  function automatic string tag_name(input int c);
    case (c)
      1: return "R1";
      2: return "R2";
      3: return "R3";
      4: return "R4";
      5: return "R5";
      6: return "R6";
      7: return "R7";
      8: return "R8";
      9: return "R9";
      default: return "R10";
    endcase
  endfunction

  // Behavioural model of the requirements, one clock behind at the ports
  bit          m_on;
  int          m_ph, m_cnt, m_dt, m_raw;
  logic [11:0] e_sw;
  logic [1:0]  e_ph;
  bit          e_v;
  int          e_tag;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_on <= 0; m_ph <= 0; m_cnt <= 0; m_dt <= 1; m_raw <= 1;
      e_sw <= '0; e_ph <= 2'd0; e_v <= 0; e_tag <= 1;
    end else begin
      e_v  <= m_on && (m_cnt >= m_dt);
      e_ph <= m_on ? 2'(m_ph) : 2'd0;
      e_sw <= exp_switches(m_ph, m_on && (m_cnt >= m_dt));
      if (in_reset)                 e_tag <= 1;
      else if (!m_on)               e_tag <= 2;
      else if (m_cnt == 0)          e_tag <= 3;
      else if (m_cnt < m_dt)        e_tag <= r9_mark ? 9 : ((m_raw == 0 || m_raw >= P) ? 8 : 7);
      else if (r9_mark)             e_tag <= 9;
      else if (m_ph == 1)           e_tag <= 5;
      else if (m_ph == 3)           e_tag <= 6;
      else                          e_tag <= 4;
      if (!en) begin
        m_on <= 0; m_ph <= 0; m_cnt <= 0;
      end else if (!m_on) begin
        m_on <= 1; m_ph <= 0; m_cnt <= 0; m_dt <= eff_dead(int'(dead)); m_raw <= int'(dead);
      end else if (m_cnt == P - 1) begin
        m_ph <= (m_ph + 1) % 4; m_cnt <= 0; m_dt <= eff_dead(int'(dead)); m_raw <= int'(dead);
      end else begin
        m_cnt <= m_cnt + 1;
      end
    end
  end

  // Comparison away from the active edge
  always @(negedge clk) begin
    if (!done) begin
      n_cmp++;
      if ({sw_b, sw_a} !== e_sw || phase_idx !== e_ph || phase_valid !== e_v) begin
        n_bad++;
        $display("FAIL %s t=%0t actual sw_b=%b sw_a=%b ph=%0d v=%0b expected sw_b=%b sw_a=%b ph=%0d v=%0b",
                 tag_name(e_tag), $time, sw_b, sw_a, phase_idx, phase_valid,
                 e_sw[11:6], e_sw[5:0], e_ph, e_v);
      end
      n_cmp++;
      if (!((sw_a == 6'b0 || sw_a == 6'b000011 || sw_a == 6'b001100 || sw_a == 6'b110000) &&
            (sw_b == 6'b0 || sw_b == 6'b000011 || sw_b == 6'b001100 || sw_b == 6'b110000))) begin
        n_bad++;
        $display("FAIL R10 t=%0t actual sw_b=%b sw_a=%b expected a single whole pair per side",
                 $time, sw_b, sw_a);
      end
    end
  end

  task automatic cycles(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic finish_run();
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog (all requirements) actual=timeout expected=completion");
      finish_run();
    end
  end

  initial begin
    n_cmp = 0; n_bad = 0; done = 0; r9_mark = 0;
    void'($urandom(32'h1F2E3D4C));
    in_reset = 1;
    rst_n = 1'b0; en = 1'b0; dead = 4'd3;
    cycles(5);                 // R1 checked on each of these cycles
    rst_n = 1'b1;
    cycles(2);
    in_reset = 0;
    cycles(4);                 // R2 idle while en low
    // Directed: nominal dead time, three full rounds (R3..R7)
    en = 1'b1; dead = 4'd3;
    cycles(3 * 4 * P + 3);
    // R8: zero request becomes one cycle
    dead = 4'd0;
    cycles(5 * P);
    // R8: oversize request becomes P-1
    dead = 4'd15;
    cycles(5 * P);
    dead = 4'(P);
    cycles(5 * P);
    // R9: raise the request mid-phase; window of the running phase stays
    dead = 4'd2;
    cycles(2 * P);
    while (m_cnt != 3) @(negedge clk);
    r9_mark = 1; dead = 4'd6;
    cycles(3);
    r9_mark = 0; dead = 4'd2;
    cycles(2 * P);
    while (m_cnt != P - 2) @(negedge clk);
    dead = 4'd5;               // held across the boundary: next phase uses 5
    cycles(3 * P);
    // R2: drop enable mid-phase, then restart
    while (m_ph != 2 || m_cnt != 5) @(negedge clk);
    en = 1'b0;
    cycles(3);
    en = 1'b1; dead = 4'd1;
    cycles(4 * P + 2);
    en = 1'b0;
    cycles(1);
    en = 1'b1;
    cycles(2 * P);
    // Random segments
    for (int s = 0; s < 300; s++) begin
      dead = 4'($urandom_range(0, 15));
      en   = ($urandom_range(0, 9) != 0);
      cycles($urandom_range(1, 40));
    end
    en = 1'b0;
    cycles(4);
    finish_run();
  end

endmodule